// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Group Carry Terms

This block is a 4-bit arithmetic/logic slice. It takes two operands, a 4-bit function code and a mode bit. In logic mode it applies one of the sixteen two-input bitwise functions to every bit position separately, and no carry moves between bits. In arithmetic mode the function code picks two 4-bit addends built from the operands. The slice adds them with full carry lookahead, plus one when an incoming carry is present.

Carry-in, carry-out and the two group terms are active-low. The group terms tell whether the slice makes a carry by itself and whether it would pass an incoming carry through. Neither depends on the carry input, so an external lookahead stage can serve many slices. Carry-out can also feed the carry input of the next slice for plain ripple chaining. The equality flag is high when every result bit is one. With the subtract code and no incoming carry, this shows that the operands are equal. Flags from several slices can be ANDed together to compare wider words.

Following the FPGA register discipline, every output is registered once, with a synchronous active-high reset.

Top module: `alu_slice`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs load `f_out`=0, `eq_out`=0, and `cout_n`=`prop_n`=`gen_n`=1.
- R2: Every output is registered. A change on any input shows at the outputs only after the next rising edge, and never combinationally.
- R3: With `logic_mode`=1, each bit of `f_out` depends only on the same bits of A and B. By code 0..15: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R4: With `logic_mode`=0, `f_out` = (U + V + c) mod 16, where c=1 when `cin_n`=0 and c=0 otherwise. The addend pairs (U,V) by code 0..15 are: (A,0), (A|B,0), (A|~B,0), (15,0), (A,A&~B), (A|B,A&~B), (A,~B), (15,A&~B), (A,A&B), (A,B), (A|~B,A&B), (15,A&B), (A,A), (A|B,A), (A|~B,A), (A,15). So code 9 adds, code 6 gives A-B-1, code 12 doubles A and code 15 gives A-1.
- R5: `cin_n`=0 adds exactly one to the arithmetic result of R4, and `cin_n`=1 adds nothing.
- R6: `cout_n` is 0 exactly when U+V+c of R4 is 16 or more. This holds in either mode. With code 6 and `cin_n`=0 this means `cout_n`=0 iff A>=B, so carry-out signals no borrow.
- R7: `gen_n` is 0 exactly when U+V is 16 or more, whatever the value of `cin_n`.
- R8: `prop_n` is 0 exactly when U|V equals 15, whatever the value of `cin_n`.
- R9: `eq_out` is 1 exactly when all four bits of `f_out` are 1. With code 6, `logic_mode`=0 and `cin_n`=1 this means A equals B.
- R10: Two slices with code 9, the lower `cout_n` feeding the upper `cin_n`, give the 8-bit sum. The upper `cout_n` is 0 iff that sum overflows 8 bits.
- R11: Two slices with code 6 and `cin_n`=1 on the lower slice compare 8-bit words. The AND of both `eq_out` flags is 1 iff the words are equal, and the upper `cout_n` is 0 iff the first word is greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| sel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| cin_n | input | 1 | Incoming carry, active low |
| f_out | output | 4 | Registered result |
| cout_n | output | 1 | Registered carry-out, active low |
| prop_n | output | 1 | Registered group propagate, active low |
| gen_n | output | 1 | Registered group generate, active low |
| eq_out | output | 1 | Registered all-ones flag |

## Verification
The only state in the slice is its output register, so any wrong internal term shows at the ports on the first edge after the input that exposes it. A wrong per-bit generate or propagate term corrupts `f_out` and usually `gen_n` or `prop_n` for certain codes and operand pairs. A wrong lookahead term shows as a bad carry-out or high result bit, and only when a carry must cross that position. That is why every code, mode, carry value and operand pair is swept, and two chained slices are checked against 8-bit sums and comparisons.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int SEL_W = 4;

  // Function codes whose meaning the assertions rely on
  localparam logic [SEL_W-1:0] SEL_SUB    = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_ADD    = 4'b1001;
  localparam logic [SEL_W-1:0] SEL_ZERO   = 4'b0011;
  localparam logic [SEL_W-1:0] SEL_PASS_A = 4'b1111;

  typedef struct packed {
    logic prop;
    logic gen;
  } pg_t;
endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_slice_pkg::*;
(
  input  logic             a_bit,
  input  logic             b_bit,
  input  logic [SEL_W-1:0] sel,
  output pg_t              pg
);
  // Propagate term uses the low code bits, generate term the high ones
  always_comb begin
    pg.prop = a_bit | (b_bit & sel[0]) | (~b_bit & sel[1]);
    pg.gen  = (a_bit & ~b_bit & sel[2]) | (a_bit & b_bit & sel[3]);
  end
endmodule

// File: rtl/alu_carry_unit.sv
module alu_carry_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             carry_in,
  output logic [WIDTH:0]   carry,
  output logic             grp_prop,
  output logic             grp_gen
);
  // AND of prop[lo..hi]; 1 for an empty span
  function automatic logic span_and(input logic [WIDTH-1:0] v, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < WIDTH; k++) begin
      if (k >= lo && k <= hi) r = r & v[k];
    end
    return r;
  endfunction

  assign carry[0] = carry_in;

  // Every carry is formed directly from the bit terms (no ripple path)
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
      logic acc;
      always_comb begin
        acc = carry_in & span_and(prop, 0, i);
        for (int j = 0; j < WIDTH; j++) begin
          if (j <= i) acc = acc | (gen[j] & span_and(prop, j + 1, i));
        end
      end
      assign carry[i+1] = acc;
    end
  endgenerate

  always_comb begin
    grp_prop = &prop;
    grp_gen  = 1'b0;
    for (int j = 0; j < WIDTH; j++) begin
      grp_gen = grp_gen | (gen[j] & span_and(prop, j + 1, WIDTH - 1));
    end
  end
endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH-1:0] carry,
  input  logic             logic_mode,
  output logic [WIDTH-1:0] f_next
);
  // Logic mode forces the carry term on, which turns the sum into the bitwise function
  always_comb begin
    f_next = prop ^ gen ^ (carry | {WIDTH{logic_mode}});
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             logic_mode,
  input  logic             cin_n,
  output logic [WIDTH-1:0] f_out,
  output logic             cout_n,
  output logic             prop_n,
  output logic             gen_n,
  output logic             eq_out
);
  pg_t              pg_w [WIDTH];
  logic [WIDTH-1:0] prop_vec;
  logic [WIDTH-1:0] gen_vec;
  logic [WIDTH:0]   carry_w;
  logic             grp_prop_w;
  logic             grp_gen_w;
  logic [WIDTH-1:0] f_next;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      alu_bit_cell u_cell (
        .a_bit (a_in[i]),
        .b_bit (b_in[i]),
        .sel   (sel),
        .pg    (pg_w[i])
      );
      assign prop_vec[i] = pg_w[i].prop;
      assign gen_vec[i]  = pg_w[i].gen;
    end
  endgenerate

  alu_carry_unit #(.WIDTH(WIDTH)) u_carry (
    .prop     (prop_vec),
    .gen      (gen_vec),
    .carry_in (~cin_n),
    .carry    (carry_w),
    .grp_prop (grp_prop_w),
    .grp_gen  (grp_gen_w)
  );

  alu_result_stage #(.WIDTH(WIDTH)) u_result (
    .prop       (prop_vec),
    .gen        (gen_vec),
    .carry      (carry_w[WIDTH-1:0]),
    .logic_mode (logic_mode),
    .f_next     (f_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out  <= '0;
      cout_n <= 1'b1;
      prop_n <= 1'b1;
      gen_n  <= 1'b1;
      eq_out <= 1'b0;
    end else begin
      f_out  <= f_next;
      cout_n <= ~carry_w[WIDTH];
      prop_n <= ~grp_prop_w;
      gen_n  <= ~grp_gen_w;
      eq_out <= &f_next;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (f_out == '0 && !eq_out && cout_n && prop_n && gen_n));

  // R3
  logic_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (logic_mode && sel == SEL_ZERO) |=> (f_out == '0));

  // R3
  logic_pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (logic_mode && sel == SEL_PASS_A) |=> (f_out == $past(a_in)));

  // R4
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && sel == SEL_ADD)
      |=> (f_out == $past(a_in + b_in + {{(WIDTH-1){1'b0}}, ~cin_n})));

  // R6
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (!logic_mode && sel == SEL_SUB && !cin_n) |=> (cout_n == ($past(a_in) < $past(b_in))));

  // R7
  gen_forces_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_n |-> !cout_n);

  // R8
  prop_passes_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!prop_n && !$past(cin_n)) |-> !cout_n);

  // R9
  eq_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    eq_out == (&f_out));
endmodule

// File: tb/alu_slice_test.sv
module alu_slice_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_in = '0, b_in = '0, sel = '0;
  logic       logic_mode = 1'b0, cin_n = 1'b1;
  logic [3:0] f_out;
  logic       cout_n, prop_n, gen_n, eq_out;

  logic [3:0] hi_a = '0, hi_b = '0, hi_sel = '0;
  logic       hi_cin_n = 1'b1;
  logic [3:0] hi_f;
  logic       hi_cout_n, hi_prop_n, hi_gen_n, hi_eq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_slice uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .sel(sel),
    .logic_mode(logic_mode), .cin_n(cin_n), .f_out(f_out), .cout_n(cout_n),
    .prop_n(prop_n), .gen_n(gen_n), .eq_out(eq_out)
  );

  alu_slice uut_hi (
    .clk(clk), .rst(rst), .a_in(hi_a), .b_in(hi_b), .sel(hi_sel),
    .logic_mode(1'b0), .cin_n(hi_cin_n), .f_out(hi_f), .cout_n(hi_cout_n),
    .prop_n(hi_prop_n), .gen_n(hi_gen_n), .eq_out(hi_eq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Addend pair chosen by the function code
  function automatic void addends(input int a, input int b, input int s, output int u, output int v);
    int nb;
    nb = 15 - b;
    case (s)
      0:  begin u = a;        v = 0;        end
      1:  begin u = a | b;    v = 0;        end
      2:  begin u = a | nb;   v = 0;        end
      3:  begin u = 15;       v = 0;        end
      4:  begin u = a;        v = a & nb;   end
      5:  begin u = a | b;    v = a & nb;   end
      6:  begin u = a;        v = nb;       end
      7:  begin u = 15;       v = a & nb;   end
      8:  begin u = a;        v = a & b;    end
      9:  begin u = a;        v = b;        end
      10: begin u = a | nb;   v = a & b;    end
      11: begin u = 15;       v = a & b;    end
      12: begin u = a;        v = a;        end
      13: begin u = a | b;    v = a;        end
      14: begin u = a | nb;   v = a;        end
      default: begin u = a;   v = 15;       end
    endcase
  endfunction

  function automatic int logic_fn(input int a, input int b, input int s);
    int r;
    case (s)
      0:  r = ~a;
      1:  r = ~(a | b);
      2:  r = ~a & b;
      3:  r = 0;
      4:  r = ~(a & b);
      5:  r = ~b;
      6:  r = a ^ b;
      7:  r = a & ~b;
      8:  r = ~a | b;
      9:  r = ~(a ^ b);
      10: r = b;
      11: r = a & b;
      12: r = 15;
      13: r = a | ~b;
      14: r = a | b;
      default: r = a;
    endcase
    return r & 15;
  endfunction

  task automatic apply_one(input int a, input int b, input int s, input bit m, input bit cn);
    int u, v, c, sum, exp_f;
    a_in = 4'(a); b_in = 4'(b); sel = 4'(s); logic_mode = m; cin_n = cn;
    @(negedge clk);
    addends(a, b, s, u, v);
    c = cn ? 0 : 1;
    sum = u + v + c;
    exp_f = m ? logic_fn(a, b, s) : (sum & 15);
    if (m)       chk(int'(f_out) == exp_f, "R3 logic result", int'(f_out), exp_f);
    else if (!cn) chk(int'(f_out) == exp_f, "R5 arith result with carry", int'(f_out), exp_f);
    else         chk(int'(f_out) == exp_f, "R4 arith result", int'(f_out), exp_f);
    chk(cout_n == (sum < 16), "R6 carry out", int'(cout_n), int'(sum < 16));
    chk(gen_n == (u + v < 16), "R7 group generate", int'(gen_n), int'(u + v < 16));
    chk(prop_n == ((u | v) != 15), "R8 group propagate", int'(prop_n), int'((u | v) != 15));
    chk(eq_out == (exp_f == 15), "R9 equality flag", int'(eq_out), int'(exp_f == 15));
    if (!m && s == 6 && !cn)
      chk(cout_n == (a < b), "R6 no-borrow on subtract", int'(cout_n), int'(a < b));
    if (!m && s == 6 && cn)
      chk(eq_out == (a == b), "R9 compare equal", int'(eq_out), int'(a == b));
  endtask

  task automatic chain_case(input int a8, input int b8, input int s, input bit cn);
    int lo_f, exp;
    a_in = 4'(a8 & 15); b_in = 4'(b8 & 15); sel = 4'(s); logic_mode = 1'b0; cin_n = cn;
    @(negedge clk);
    lo_f = int'(f_out);
    hi_a = 4'(a8 >> 4); hi_b = 4'(b8 >> 4); hi_sel = 4'(s); hi_cin_n = cout_n;
    @(negedge clk);
    if (s == 9) begin
      exp = a8 + b8 + (cn ? 0 : 1);
      chk(((int'(hi_f) << 4) | lo_f) == (exp & 255), "R10 chained sum", (int'(hi_f) << 4) | lo_f, exp & 255);
      chk(hi_cout_n == (exp < 256), "R10 chained carry out", int'(hi_cout_n), int'(exp < 256));
    end else begin
      chk((eq_out & hi_eq) == (a8 == b8), "R11 wired-AND equal", int'(eq_out & hi_eq), int'(a8 == b8));
      chk(hi_cout_n == !(a8 > b8), "R11 greater-than via carry", int'(hi_cout_n), int'(!(a8 > b8)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(f_out == 4'd0, "R1 reset result", int'(f_out), 0);
    chk(eq_out == 1'b0, "R1 reset flag", int'(eq_out), 0);
    chk({cout_n, prop_n, gen_n} == 3'b111, "R1 reset carry terms", int'({cout_n, prop_n, gen_n}), 7);
    rst = 1'b0;

    // R2: inputs change at the falling edge, output waits for the rising edge
    a_in = 4'd5; b_in = 4'd3; sel = 4'd9; logic_mode = 1'b0; cin_n = 1'b1;
    #1;
    chk(f_out == 4'd0, "R2 no combinational path", int'(f_out), 0);
    @(negedge clk);
    chk(f_out == 4'd8, "R2 one-cycle latency", int'(f_out), 8);

    for (int m = 0; m < 2; m++)
      for (int cn = 0; cn < 2; cn++)
        for (int s = 0; s < 16; s++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              apply_one(a, b, s, m[0], cn[0]);

    for (int k = 0; k < 48; k++) begin
      int x, y;
      x = (k * 37 + 11) & 255;
      y = (k * 91 + 200) & 255;
      chain_case(x, y, 9, k[0]);
      chain_case(x, (k % 3 == 0) ? x : y, 6, 1'b1);
    end
    chain_case(255, 1, 9, 1'b1);
    chain_case(255, 255, 9, 1'b0);
    chain_case(128, 127, 6, 1'b1);
    chain_case(127, 128, 6, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule